// File: doc/BRIEF.md
# Late-Arrival Detecting Pipeline Register

This block is a bank of pipeline flops that notices when its input settled too late to be caught on the clock edge. Each bit is captured by a main flop on the rising edge of `clk`. It is also followed by a shadow latch that is open while a second, phase-shifted clock `clk_dly` is high. A late change to the input therefore reaches the shadow latch but misses the main flop. At the next main edge the two copies are compared. Any difference is reported per bit and as a single stall request, and the shadow copy is written into the main flop in place of new data.

After a correction the register holds the repaired word for one more edge while the stall request is high. It then resumes loading. A capture that was not loaded from the input is not compared: this covers the first edge after reset, the correction edge and the hold edge. A saturating counter totals the correction events, so that a supply controller can judge how close the logic runs to its limit.

The delayed clock must rise after `clk` and fall before the next rising edge of `clk`. The input must hold steady while `clk_dly` is high.

Top module: `latecatch_reg`

## Requirements
- R1: An active-low asynchronous reset clears `dout`, `err_bits`, `err_stall`, `err_cnt` and the shadow copy to zero.
- R2: When the input is steady from before a rising `clk` edge until `clk_dly` falls, `dout` presents that input after the edge and no error is raised.
- R3: If the shadow copy differs from the word the main flop loaded at the previous edge, then at the next edge `err_bits` shows the XOR of the two words (a 1 marks each bit that arrived late).
- R4: At the edge that raises the error, `dout` takes the shadow copy instead of the current input.
- R5: `err_stall` stays high for exactly one cycle per error, and during that cycle's closing edge `dout` holds the repaired word and `err_bits` clears.
- R6: No comparison is made for a capture that did not come from the input: the first edge after reset and the first edge after a stall load the input without raising an error, whatever the shadow holds.
- R7: `err_cnt` goes up by one at each edge that raises an error and stays at its all-ones value (31 for a 5-bit counter, 255 at the default 8 bits) once reached; it does not change at any other edge.
- R8: `err_stall` is high exactly when `err_bits` is nonzero.
- R9: An input glitch that settles back to the captured value before `clk_dly` rises causes no error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main capture clock, rising edge |
| clk_dly | input | 1 | Delayed clock; the shadow latch is open while it is high |
| rst_n | input | 1 | Asynchronous reset, active low |
| din | input | WIDTH | Data from the preceding logic stage |
| dout | output | WIDTH | Registered, corrected data to the next stage |
| err_bits | output | WIDTH | Per-bit late-arrival flags for the current cycle |
| err_stall | output | 1 | Global error, requests a one-cycle pipeline stall |
| err_cnt | output | CNT_W | Saturating count of correction events |

## Verification
The bench builds the block with WIDTH at 12 and CNT_W at 5. The narrower counter tops out at 31, so a few hundred random cycles with frequent late arrivals drive it into saturation and keep it there. The 12-bit word lets random late values produce single-bit, multi-bit and zero-difference mismatches. Directed cycles add glitches before the delayed edge, late changes that land on the same value, and resets in the middle of a run.

// File: rtl/latecatch_reg.sv
`timescale 1ns/100ps
module latecatch_reg #(
  parameter int WIDTH = 16,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             clk_dly,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic [WIDTH-1:0] err_bits,
  output logic             err_stall,
  output logic [CNT_W-1:0] err_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [WIDTH-1:0] shadow;
  logic             armed;
  logic [WIDTH-1:0] diff;
  logic             hit;

  always_latch begin
    if (!rst_n)       shadow = '0;
    else if (clk_dly) shadow = din;
  end

  assign diff = armed ? (dout ^ shadow) : '0;
  assign hit  = |diff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout      <= '0;
      armed     <= 1'b0;
      err_bits  <= '0;
      err_stall <= 1'b0;
      err_cnt   <= '0;
    end else if (hit) begin
      dout      <= shadow;
      armed     <= 1'b0;
      err_bits  <= diff;
      err_stall <= 1'b1;
      if (err_cnt != CNT_MAX) err_cnt <= err_cnt + 1'b1;
    end else if (err_stall) begin
      armed     <= 1'b0;
      err_bits  <= '0;
      err_stall <= 1'b0;
    end else begin
      dout      <= din;
      armed     <= 1'b1;
      err_bits  <= '0;
      err_stall <= 1'b0;
    end
  end
endmodule

// File: rtl/latecatch_chk.sv
`timescale 1ns/100ps
module latecatch_chk #(
  parameter int WIDTH = 16,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] dout,
  input logic [WIDTH-1:0] shadow,
  input logic [WIDTH-1:0] err_bits,
  input logic             err_stall,
  input logic [CNT_W-1:0] err_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  assert_repair_R4: assert property (@(posedge clk) disable iff (!rst_n)
    err_stall |-> dout == $past(shadow));

  assert_single_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err_stall |=> !err_stall && $stable(dout) && err_bits == '0);

  assert_no_recheck_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err_stall |=> ##1 !err_stall);

  assert_count_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_stall && $past(err_cnt) != CNT_MAX) |-> err_cnt == $past(err_cnt) + 1'b1);

  assert_count_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_stall || $past(err_cnt) == CNT_MAX) |-> err_cnt == $past(err_cnt));

  assert_global_or_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_stall == (err_bits != '0));
endmodule

bind latecatch_reg latecatch_chk #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .dout(dout), .shadow(shadow),
  .err_bits(err_bits), .err_stall(err_stall), .err_cnt(err_cnt)
);

// File: tb/sim_latecatch_reg.sv
`timescale 1ns/100ps
module sim_latecatch_reg;
  localparam int   W   = 12;
  localparam int   CW  = 5;
  localparam real  PER = 10.0;
  localparam logic [CW-1:0] CMAX = '1;

  logic clk, clk_dly, rst_n;
  logic [W-1:0]  d;
  logic [W-1:0]  dout, err_bits;
  logic          err_stall;
  logic [CW-1:0] err_cnt;

  int nchk = 0, nfail = 0;
  logic [W-1:0]  m_q, m_sh, m_err;
  logic          m_vld, m_stall;
  logic [CW-1:0] m_cnt;
  string         tq;

  latecatch_reg #(.WIDTH(W), .CNT_W(CW)) u0 (
    .clk(clk), .clk_dly(clk_dly), .rst_n(rst_n), .din(d),
    .dout(dout), .err_bits(err_bits), .err_stall(err_stall), .err_cnt(err_cnt));

  initial begin clk = 0; forever #(PER/2) clk = ~clk; end
  initial begin clk_dly = 0; #2; forever #(PER/2) clk_dly = ~clk_dly; end

  function automatic logic [W-1:0] exp_diff(logic [W-1:0] a, logic [W-1:0] b, logic v);
    return v ? (a ^ b) : '0;
  endfunction

  task automatic chk(logic [31:0] act, logic [31:0] exp, string tag);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_q = '0; m_sh = '0; m_err = '0; m_vld = 0; m_stall = 0; m_cnt = '0;
  endtask

  task automatic model_edge();
    logic [W-1:0] mis;
    mis = exp_diff(m_q, m_sh, m_vld);
    if (mis != '0) begin
      tq = "R4"; m_q = m_sh; m_vld = 0; m_stall = 1; m_err = mis;
      if (m_cnt != CMAX) m_cnt = m_cnt + 1'b1;
    end else if (m_stall) begin
      tq = "R5"; m_vld = 0; m_stall = 0; m_err = '0;
    end else begin
      tq = m_vld ? "R2" : "R6";
      m_q = d; m_vld = 1; m_stall = 0; m_err = '0;
    end
  endtask

  task automatic check_all();
    chk(32'(dout), 32'(m_q), tq);
    chk(32'(err_bits), 32'(m_err), "R3");
    chk(32'(err_stall), 32'(m_stall), "R8");
    chk(32'(err_cnt), 32'(m_cnt), "R7");
  endtask

  task automatic cyc(bit late, bit glitch, logic [W-1:0] lval, logic [W-1:0] nxt);
    logic [W-1:0] keep;
    @(posedge clk);
    model_edge();
    #1;
    if (glitch) begin
      keep = d; d = lval; #0.5; d = keep; #2.5;
    end else begin
      if (late) d = lval;
      #3;
    end
    m_sh = d;
    check_all();
    #4;
    d = nxt;
  endtask

  task automatic mid_reset();
    rst_n = 0;
    model_reset();
    #1;
    chk(32'(dout), 0, "R1"); chk(32'(err_bits), 0, "R1");
    chk(32'(err_stall), 0, "R1"); chk(32'(err_cnt), 0, "R1");
    @(posedge clk); #8;
    rst_n = 1;
  endtask

  initial begin
    #(PER * 200000);
    nfail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int unsigned seed;
    logic [W-1:0] v;
    seed = $urandom(32'd4242);
    rst_n = 0; d = '0; model_reset(); tq = "R1";
    repeat (3) @(posedge clk);
    #4;
    chk(32'(dout), 0, "R1"); chk(32'(err_bits), 0, "R1");
    chk(32'(err_stall), 0, "R1"); chk(32'(err_cnt), 0, "R1");
    #4; rst_n = 1; d = 12'h5a5;
    // R2: steady data
    cyc(0, 0, '0, 12'h0f0);
    cyc(0, 0, '0, 12'hfff);
    cyc(0, 0, '0, 12'h001);
    // R3/R4: single-bit late arrival, then R5 hold, R6 reload
    cyc(1, 0, 12'h003, 12'h800);
    cyc(0, 0, '0, 12'h123);
    cyc(0, 0, '0, 12'h456);
    cyc(0, 0, '0, 12'h789);
    // multi-bit late arrival
    cyc(1, 0, 12'h876, 12'h111);
    cyc(0, 0, '0, 12'h222);
    cyc(0, 0, '0, 12'h333);
    cyc(0, 0, '0, 12'h444);
    // late change to identical value: no error
    cyc(1, 0, 12'h444, 12'h555);
    cyc(0, 0, '0, 12'h666);
    // R9: early glitch that settles back
    cyc(0, 1, 12'h999, 12'h777);
    cyc(0, 1, 12'h000, 12'h777);
    cyc(0, 0, '0, 12'h0aa);
    // late change during stall and reload cycles (R6)
    cyc(1, 0, 12'hbbb, 12'h0cc);
    cyc(1, 0, 12'hddd, 12'h0ee);
    cyc(1, 0, 12'h321, 12'h654);
    cyc(0, 0, '0, 12'h654);
    // R1: reset in the middle of a run
    mid_reset();
    cyc(0, 0, '0, 12'h10f);
    cyc(1, 0, 12'h10e, 12'h200);
    cyc(0, 0, '0, 12'h300);
    // random mix, drives counter into saturation (R7)
    for (int i = 0; i < 1500; i++) begin
      v = W'($urandom);
      cyc(($urandom % 10) < 3, ($urandom % 20) == 0, v, W'($urandom));
      if (i == 700) mid_reset();
    end
    chk(32'(err_cnt), 32'(CMAX), "R7");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule